// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Sequencer

This block keeps an asynchronous EDO DRAM with two byte-lane column strobes refreshed. In normal operation an interval timer raises a refresh need every fixed number of clock cycles. The sequencer then asks a shared arbiter for the memory bus with a request/grant handshake. Once it has the bus it runs a CAS-before-RAS cycle: both column strobes fall together, RAS falls a set number of cycles later, and all strobes rise together after the RAS-active time. A normal precharge gap follows. The default timing targets a 4096-row array with one refresh every 15.6 µs, a full pass every 64 ms, and a 250 MHz clock. A 1024-row, 16 ms array needs only the row count and interval parameters changed.

Self-refresh is entered on request. Entry is allowed only after a full sweep of distributed refreshes, one for every row, has run since reset or since the previous exit. This guarantees a complete pass before each entry and a complete pass after each exit. While in self-refresh, RAS is held low for at least the self-refresh minimum. This keeps every RAS low time out of the window between the transition threshold and that minimum. On exit the longer self-refresh precharge applies. The interval timer then restarts from zero and the sweep count clears.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted and just after it is released, RAS and both CAS strobes are high (1), and the bus request, busy and late-error outputs are low.
- R2: With the grant held high and no self-refresh request, the bus request rises once every INTERVAL_CYC cycles.
- R3: The upper and lower CAS strobes are always equal. Before every RAS fall they are low for exactly CAS_SETUP_CYC cycles while RAS is still high.
- R4: A distributed refresh holds RAS low for exactly RAS_ACT_CYC cycles and then releases RAS and both CAS strobes together. Busy then stays high with all strobes high for exactly PRECH_CYC cycles.
- R5: No strobe moves without the grant. While a request waits for the grant, RAS and CAS stay high and busy stays low. The request stays pending, and the CAS strobes fall one cycle after the grant is seen.
- R6: If a full interval expires while an earlier refresh is still waiting for the grant, the late-error output rises on that expiry and stays high until reset. A shorter wait leaves it low.
- R7: Self-refresh is entered only after ROW_COUNT distributed refreshes have completed since reset or since the last self-refresh exit. Until then, refreshes continue as normal.
- R8: In self-refresh, RAS stays low for at least SR_MIN_CYC cycles and until the self-refresh request is low. It rises on the first clock edge at which both conditions hold.
- R9: After self-refresh, busy stays high with all strobes high for exactly SR_PRECH_CYC cycles before the bus is released.
- R10: Every RAS low time is either shorter than FORBID_LO_CYC or at least SR_MIN_CYC.
- R11: The interval timer is held at zero during self-refresh and its precharge. The first request after exit rises INTERVAL_CYC+1 cycles after busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sr_req_i | input | 1 | High requests self-refresh; low requests exit |
| gnt_i | input | 1 | Bus grant from the arbiter |
| req_o | output | 1 | Bus request to the arbiter |
| ras_n_o | output | 1 | Row strobe, active low |
| ucas_n_o | output | 1 | Upper byte-lane column strobe, active low |
| lcas_n_o | output | 1 | Lower byte-lane column strobe, active low |
| busy_o | output | 1 | High while the sequencer drives a strobe cycle or precharge |
| late_err_o | output | 1 | Sticky flag: a refresh waited longer than one interval |

## Verification
A corrupt interval counter shows up within one interval as a wrong spacing between request edges, and also as a wrong gap after self-refresh exit. A sweep count that clears or saturates wrongly lets self-refresh start before the required number of refreshes, or keeps it locked out. This is visible at the first RAS fall that begins a long low period. A state machine in the wrong state gives a RAS or busy run of the wrong length. That shows up at the next strobe rise or busy fall, within a few cycles.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_CAS_SU,
    ST_RAS_ACT,
    ST_PRECH,
    ST_SR_HOLD,
    ST_SR_PRECH
  } seq_state_t;

  // bits needed to hold the value n
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // a RAS low run is legal if short of the transition window or past it
  function automatic logic ras_low_legal(input int unsigned len,
                                         input int unsigned forbid,
                                         input int unsigned sr_min);
    return (len < forbid) || (len >= sr_min);
  endfunction

  // precharge needed after a low run of the given length
  function automatic int unsigned prech_needed(input logic was_long,
                                               input int unsigned normal,
                                               input int unsigned longer);
    return was_long ? longer : normal;
  endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int unsigned PERIOD_CYC = 3900
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o,
  output logic pend_o,
  output logic late_o
);
  localparam int unsigned TW = (PERIOD_CYC < 3) ? 1 : $clog2(PERIOD_CYC);
  localparam logic [TW-1:0] LAST = TW'(PERIOD_CYC - 1);

  logic [TW-1:0] tcnt_q;

  assign tick_o = run_i && (tcnt_q == LAST);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      tcnt_q <= '0;
      pend_o <= 1'b0;
      late_o <= 1'b0;
    end else begin
      if (!run_i || tick_o) tcnt_q <= '0;
      else                  tcnt_q <= tcnt_q + 1'b1;
      pend_o <= (pend_o && !clr_i) || tick_o;
      late_o <= late_o || (tick_o && pend_o && !clr_i);
    end
  end
endmodule

// File: rtl/ref_sweep_counter.sv
module ref_sweep_counter
  import dram_ref_pkg::*;
#(
  parameter int unsigned ROWS = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic clr_i,
  output logic full_o
);
  localparam int unsigned SW = cnt_bits(ROWS);
  localparam logic [SW-1:0] TOP = SW'(ROWS);

  logic [SW-1:0] rows_q;

  assign full_o = (rows_q == TOP);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                rows_q <= '0;
    else if (clr_i)             rows_q <= '0;
    else if (inc_i && !full_o)  rows_q <= rows_q + 1'b1;
  end
endmodule

// File: rtl/ref_seq_fsm.sv
module ref_seq_fsm
  import dram_ref_pkg::*;
#(
  parameter int unsigned CAS_SETUP_CYC = 3,
  parameter int unsigned RAS_ACT_CYC   = 15,
  parameter int unsigned PRECH_CYC     = 12,
  parameter int unsigned SR_MIN_CYC    = 25000,
  parameter int unsigned SR_PRECH_CYC  = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  input  logic sweep_full_i,
  input  logic sr_req_i,
  input  logic gnt_i,
  output logic ref_start_o,
  output logic ref_done_o,
  output logic sr_enter_o,
  output logic sr_exit_o,
  output logic timer_run_o,
  output logic req_o,
  output logic busy_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int unsigned MAXC =
    max2(max2(max2(CAS_SETUP_CYC, RAS_ACT_CYC), max2(PRECH_CYC, SR_PRECH_CYC)), SR_MIN_CYC);
  localparam int unsigned CW = cnt_bits(MAXC);
  localparam logic [CW-1:0] CAS_LAST  = CW'(CAS_SETUP_CYC - 1);
  localparam logic [CW-1:0] RAS_LAST  = CW'(RAS_ACT_CYC - 1);
  localparam logic [CW-1:0] PRE_LAST  = CW'(PRECH_CYC - 1);
  localparam logic [CW-1:0] SRM_LAST  = CW'(SR_MIN_CYC - 1);
  localparam logic [CW-1:0] SRP_LAST  = CW'(SR_PRECH_CYC - 1);

  seq_state_t state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic kind_sr_q, kind_sr_d;

  logic cas_done, ras_done, pre_done, srp_done, sr_min_met;

  assign cas_done   = (cnt_q == CAS_LAST);
  assign ras_done   = (cnt_q == RAS_LAST);
  assign pre_done   = (cnt_q == PRE_LAST);
  assign srp_done   = (cnt_q == SRP_LAST);
  assign sr_min_met = (cnt_q >= SRM_LAST);

  assign ref_start_o = (state_q == ST_REQ) && gnt_i && !kind_sr_q;
  assign ref_done_o  = (state_q == ST_RAS_ACT) && ras_done;
  assign sr_enter_o  = (state_q == ST_CAS_SU) && cas_done && kind_sr_q;
  assign sr_exit_o   = (state_q == ST_SR_HOLD) && sr_min_met && !sr_req_i;
  assign timer_run_o = !((state_q == ST_SR_HOLD) || (state_q == ST_SR_PRECH));

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    kind_sr_d = kind_sr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (pend_i) begin
          state_d   = ST_REQ;
          kind_sr_d = 1'b0;
        end else if (sr_req_i && sweep_full_i) begin
          state_d   = ST_REQ;
          kind_sr_d = 1'b1;
        end
      end
      ST_REQ: begin
        if (gnt_i) begin
          state_d = ST_CAS_SU;
          cnt_d   = '0;
        end
      end
      ST_CAS_SU: begin
        if (cas_done) begin
          state_d = kind_sr_q ? ST_SR_HOLD : ST_RAS_ACT;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RAS_ACT: begin
        if (ras_done) begin
          state_d = ST_PRECH;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PRECH: begin
        if (pre_done) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SR_HOLD: begin
        if (sr_exit_o) begin
          state_d = ST_SR_PRECH;
          cnt_d   = '0;
        end else if (!sr_min_met) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SR_PRECH: begin
        if (srp_done) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      kind_sr_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      kind_sr_q <= kind_sr_d;
    end
  end

  assign req_o   = (state_q != ST_IDLE);
  assign busy_o  = (state_q != ST_IDLE) && (state_q != ST_REQ);
  assign cas_n_o = !((state_q == ST_CAS_SU) || (state_q == ST_RAS_ACT) || (state_q == ST_SR_HOLD));
  assign ras_n_o = !((state_q == ST_RAS_ACT) || (state_q == ST_SR_HOLD));
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
#(
  parameter int unsigned INTERVAL_CYC  = 3900,
  parameter int unsigned ROW_COUNT     = 4096,
  parameter int unsigned CAS_SETUP_CYC = 3,
  parameter int unsigned RAS_ACT_CYC   = 15,
  parameter int unsigned PRECH_CYC     = 12,
  parameter int unsigned FORBID_LO_CYC = 2500,
  parameter int unsigned SR_MIN_CYC    = 25000,
  parameter int unsigned SR_PRECH_CYC  = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sr_req_i,
  input  logic gnt_i,
  output logic req_o,
  output logic ras_n_o,
  output logic ucas_n_o,
  output logic lcas_n_o,
  output logic busy_o,
  output logic late_err_o
);
  localparam int unsigned LANES = 2;

  logic tick, pend, sweep_full;
  logic ref_start, ref_done, sr_enter, sr_exit, timer_run;
  logic cas_n;
  logic [LANES-1:0] cas_lane_n;

  ref_interval_timer #(
    .PERIOD_CYC(INTERVAL_CYC)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (timer_run),
    .clr_i (ref_start || sr_enter),
    .tick_o(tick),
    .pend_o(pend),
    .late_o(late_err_o)
  );

  ref_sweep_counter #(
    .ROWS(ROW_COUNT)
  ) u_sweep (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (ref_done),
    .clr_i (sr_exit),
    .full_o(sweep_full)
  );

  ref_seq_fsm #(
    .CAS_SETUP_CYC(CAS_SETUP_CYC),
    .RAS_ACT_CYC  (RAS_ACT_CYC),
    .PRECH_CYC    (PRECH_CYC),
    .SR_MIN_CYC   (SR_MIN_CYC),
    .SR_PRECH_CYC (SR_PRECH_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pend_i      (pend),
    .sweep_full_i(sweep_full),
    .sr_req_i    (sr_req_i),
    .gnt_i       (gnt_i),
    .ref_start_o (ref_start),
    .ref_done_o  (ref_done),
    .sr_enter_o  (sr_enter),
    .sr_exit_o   (sr_exit),
    .timer_run_o (timer_run),
    .req_o       (req_o),
    .busy_o      (busy_o),
    .ras_n_o     (ras_n_o),
    .cas_n_o     (cas_n)
  );

  // both byte lanes follow one strobe so the effective edges coincide
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cas_lane_n[g] = cas_n;
  end

  assign ucas_n_o = cas_lane_n[1];
  assign lcas_n_o = cas_lane_n[0];

  // tick is consumed inside the timer; keep it visible for the checker
  logic tick_seen;
  assign tick_seen = tick;
endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk
  import dram_ref_pkg::*;
#(
  parameter int unsigned PRECH_CYC     = 12,
  parameter int unsigned FORBID_LO_CYC = 2500,
  parameter int unsigned SR_MIN_CYC    = 25000,
  parameter int unsigned SR_PRECH_CYC  = 30
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic ucas_n,
  input logic lcas_n,
  input logic req,
  input logic busy,
  input logic late_err,
  input logic gnt,
  input logic sweep_full,
  input logic sr_enter,
  input logic tick
);
  int unsigned lo_cnt, hi_cnt;
  logic was_long, seen_low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cnt   <= 0;
      hi_cnt   <= 0;
      was_long <= 1'b0;
      seen_low <= 1'b0;
    end else begin
      if (!ras_n) begin
        lo_cnt   <= lo_cnt + 32'd1;
        hi_cnt   <= 0;
        seen_low <= 1'b1;
      end else begin
        lo_cnt <= 0;
        hi_cnt <= hi_cnt + 32'd1;
        if (lo_cnt != 0) was_long <= (lo_cnt >= SR_MIN_CYC);
      end
    end
  end

  p_lanes_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ucas_n == lcas_n);

  p_cas_leads_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!ucas_n && $past(!ucas_n)));

  p_cas_needs_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ucas_n) |-> $past(gnt));

  p_busy_under_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> req);

  p_late_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    late_err |=> late_err);

  p_no_tick_in_sr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && lo_cnt > 1 && lo_cnt >= SR_MIN_CYC) |-> !tick);

  p_sr_needs_sweep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sr_enter |-> sweep_full);

  p_ras_low_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && lo_cnt != 0) |-> ras_low_legal(lo_cnt, FORBID_LO_CYC, SR_MIN_CYC));

  p_precharge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && hi_cnt != 0 && seen_low) |->
      (hi_cnt >= prech_needed(was_long, PRECH_CYC, SR_PRECH_CYC)));
endmodule

bind dram_refresh_seq dram_refresh_chk #(
  .PRECH_CYC    (PRECH_CYC),
  .FORBID_LO_CYC(FORBID_LO_CYC),
  .SR_MIN_CYC   (SR_MIN_CYC),
  .SR_PRECH_CYC (SR_PRECH_CYC)
) u_chk (
  .clk       (clk_i),
  .rst_n     (rst_ni),
  .ras_n     (ras_n_o),
  .ucas_n    (ucas_n_o),
  .lcas_n    (lcas_n_o),
  .req       (req_o),
  .busy      (busy_o),
  .late_err  (late_err_o),
  .gnt       (gnt_i),
  .sweep_full(sweep_full),
  .sr_enter  (sr_enter),
  .tick      (tick_seen)
);

// File: tb/sim_dram_refresh_seq.sv
`timescale 1ns/1ps
module sim_dram_refresh_seq;
  localparam int INTERVAL = 40;
  localparam int ROWS     = 8;
  localparam int CASSU    = 2;
  localparam int RASACT   = 5;
  localparam int PRE      = 4;
  localparam int FORBID   = 12;
  localparam int SRMIN    = 30;
  localparam int SRPRE    = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sr_req = 1'b0;
  logic gnt = 1'b1;
  logic req, ras_n, ucas_n, lcas_n, busy, err;

  always #2 clk = ~clk;

  dram_refresh_seq #(
    .INTERVAL_CYC(INTERVAL), .ROW_COUNT(ROWS), .CAS_SETUP_CYC(CASSU),
    .RAS_ACT_CYC(RASACT), .PRECH_CYC(PRE), .FORBID_LO_CYC(FORBID),
    .SR_MIN_CYC(SRMIN), .SR_PRECH_CYC(SRPRE)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sr_req_i(sr_req), .gnt_i(gnt),
    .req_o(req), .ras_n_o(ras_n), .ucas_n_o(ucas_n), .lcas_n_o(lcas_n),
    .busy_o(busy), .late_err_o(err)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor state, sampled at falling edges
  int cyc = 0, n_fall = 0, n_ref = 0, n_sr = 0, ref_since_exit = 0, ref_at_fall = 0;
  int sr_ref_at_entry = 0, sr_len = 0, low_len = 0, cas_lead = 0, tail = 0;
  int lane_mis = 0, last_req_cyc = 0, exit_cyc = 0;
  bit prev_ras = 1, prev_req = 0, in_tail = 0, long_tail = 0, per_en = 0, gap_done = 1;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (ucas_n != lcas_n) lane_mis++;
      if (prev_ras && !ras_n) begin
        n_fall++;
        ref_at_fall = ref_since_exit;
        chk(cas_lead == CASSU, "R3 cas lead", cas_lead, CASSU);
      end
      if (!ucas_n && ras_n) cas_lead++;
      else cas_lead = 0;
      if (!ras_n) low_len++;
      if (!prev_ras && ras_n) begin
        chk((low_len < FORBID) || (low_len >= SRMIN), "R10 low window", low_len, SRMIN);
        if (low_len >= SRMIN) begin
          n_sr++;
          sr_len = low_len;
          sr_ref_at_entry = ref_at_fall;
          ref_since_exit = 0;
          long_tail = 1;
          gap_done = 0;
        end else begin
          chk(low_len == RASACT, "R4 ras active", low_len, RASACT);
          ref_since_exit++;
          n_ref++;
          long_tail = 0;
        end
        low_len = 0;
        in_tail = 1;
        tail = 0;
      end
      if (in_tail) begin
        if (busy) tail++;
        else begin
          in_tail = 0;
          if (long_tail) begin
            chk(tail == SRPRE, "R9 sr precharge", tail, SRPRE);
            exit_cyc = cyc;
          end else begin
            chk(tail == PRE, "R4 precharge", tail, PRE);
          end
        end
      end
      if (!prev_req && req) begin
        if (per_en && last_req_cyc != 0)
          chk(cyc - last_req_cyc == INTERVAL, "R2 period", cyc - last_req_cyc, INTERVAL);
        last_req_cyc = cyc;
        if (!gap_done) begin
          chk(cyc - exit_cyc == INTERVAL + 1, "R11 restart gap", cyc - exit_cyc, INTERVAL + 1);
          gap_done = 1;
        end
      end
      prev_ras = ras_n;
      prev_req = req;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ras_n && ucas_n && lcas_n && !req && !busy && !err, "R1 in reset",
        {27'd0, ras_n, ucas_n, lcas_n, req, busy}, 28);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && ucas_n && lcas_n && !req && !busy && !err, "R1 after release",
        {27'd0, ras_n, ucas_n, lcas_n, req, busy}, 28);

    // plain periodic refresh; sweep not yet full
    per_en = 1;
    wait (n_ref == 3);
    per_en = 0;
    sr_req = 1'b1;

    // first self-refresh: entry only after the full sweep, release early
    wait (n_fall == ROWS + 1);
    @(negedge clk);
    sr_req = 1'b0;
    wait (n_sr == 1);
    chk(sr_ref_at_entry == ROWS, "R7 first entry", sr_ref_at_entry, ROWS);
    chk(sr_len == SRMIN, "R8 minimum hold", sr_len, SRMIN);
    wait (exit_cyc != 0);
    sr_req = 1'b1;
    wait (gap_done);

    // second self-refresh: sweep restarted, held past the minimum
    wait (n_fall == 2 * ROWS + 2);
    repeat (50) @(negedge clk);
    sr_req = 1'b0;
    @(negedge clk);
    chk(ras_n == 1'b1, "R8 prompt exit", ras_n, 1);
    wait (n_sr == 2);
    chk(sr_ref_at_entry == ROWS, "R7 second entry", sr_ref_at_entry, ROWS);
    chk(sr_len == 51, "R8 held by request", sr_len, 51);
    gnt = 1'b0;
    wait (gap_done);

    // delayed grant shorter than an interval
    @(negedge clk);
    chk(req == 1'b1, "R5 request raised", req, 1);
    begin
      int bad = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (!ras_n || !ucas_n || !lcas_n || busy || !req) bad++;
      end
      chk(bad == 0, "R5 quiet without grant", bad, 0);
    end
    chk(err == 1'b0, "R6 short wait", err, 0);
    gnt = 1'b1;
    @(negedge clk);
    chk(ucas_n == 1'b0 && lcas_n == 1'b0, "R5 cas after grant", ucas_n, 0);

    // grant withheld beyond one interval
    wait (busy == 1'b0 && req == 1'b0);
    gnt = 1'b0;
    @(negedge clk);
    while (!req) @(negedge clk);
    repeat (INTERVAL - 2) @(negedge clk);
    chk(err == 1'b0, "R6 before expiry", err, 0);
    @(negedge clk);
    chk(err == 1'b1, "R6 on expiry", err, 1);
    gnt = 1'b1;
    repeat (60) @(negedge clk);
    chk(err == 1'b1, "R6 sticky", err, 1);

    chk(lane_mis == 0, "R3 lanes equal", lane_mis, 0);
    chk(n_ref >= 2 * ROWS, "R2 refresh count", n_ref, 2 * ROWS);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule